// File: doc/BRIEF.md
# EPP Parallel Port Host Controller

This block is the host end of an Enhanced Parallel Port link. A CPU reaches it through eight byte-wide registers selected by a 3-bit offset. Three of them are plain registers: the output data latch, the status view and the line-control register. The other five start a hardware-timed transfer with the peripheral when the CPU accesses them. Offset 3 starts an address transfer. Offsets 4 to 7 start a data transfer, and all four offsets use the same 8-bit data register.

During a transfer the block drives the active-low write line and the address or data strobe. It also sets the direction of the data bus and follows the peripheral's wait handshake. The CPU sees `cpu_busy` while a transfer runs and a one-cycle `cpu_done` when it ends. When a read ends, the byte captured from the bus is on `cpu_rdata`.

Under protocol version 1.9, a transfer that has not finished within a set number of clocks is aborted and flags a timeout. A new transfer cannot start until software clears that flag. The default of 1250 clocks is 10 µs at 125 MHz. Inputs select the protocol version, enable transfer mode, and let software take over the bus direction.

Top module: `epp_host`

## Requirements
- R1: After reset, the address register (offset 3), the data register (offset 4), the control register (offset 2) and status bit 0 read as 0. All three strobe lines are high.
- R2: With `epp_en`=1, a write to offset 3 runs an address transfer. `naddrstb` goes low while `nwrite` is low and `pd_out` carries the byte. The strobe returns high after `per_wait` rises, and `cpu_done` pulses once after `per_wait` falls again.
- R3: Control bits 7 and 6 always read as 0. Bits 5:0 read back as written.
- R4: In a write transfer, `nwrite` is low and `pd_out` is valid one clock before the strobe falls. In that setup clock both strobes are still high.
- R5: A write to any of offsets 4 to 7 runs a data transfer on `ndatastb`, and the data byte is driven on `pd_out`.
- R6: The bus direction `pd_oe` (1 = block drives) works as follows. With `epp_en`=0 it is 1 whatever control bit 5 holds. With `epp_en`=1 it is the inverse of control bit 5 while no transfer runs. During hardware-directed transfers it is 1 for writes and 0 for reads.
- R7: A read of offset 3 or of offsets 4 to 7 runs a read transfer. `pd_in` is captured when `per_wait` rises, and that byte is on `cpu_rdata` in the `cpu_done` cycle.
- R8: With `cfg_v17`=0, a transfer still running `TMO_CYCLES` clocks after it starts is aborted. The strobes and `nwrite` return high, `cpu_done` pulses, and status bit 0 is set.
- R9: With `cfg_v17`=1 there is no timeout, and a transfer waits for the peripheral however long that takes.
- R10: While status bit 0 is set, accesses to offsets 3 to 7 start no transfer. Writing offset 1 with bit 0 = 1 clears the bit.
- R11: With `cfg_swdir`=1, `pd_oe` is the inverse of control bit 5 at all times, including during transfers.
- R12: With `epp_en`=0, accesses to offsets 3 to 7 start no transfer and leave the address and data registers unchanged.
- R13: Control bit 0 forces `nwrite` low, control bit 1 forces `ndatastb` low and control bit 3 forces `naddrstb` low. With these bits at 0 the lines idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | One-clock write request |
| cpu_rd | input | 1 | One-clock read request (starts a transfer at offsets 3 to 7) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Contents of the register selected by `cpu_addr` |
| cpu_busy | output | 1 | A transfer is running |
| cpu_done | output | 1 | One-clock pulse when a transfer ends |
| epp_en | input | 1 | 1 = transfer mode, 0 = compatible mode |
| cfg_v17 | input | 1 | 1 = protocol version 1.7 (no timeout), 0 = version 1.9 |
| cfg_swdir | input | 1 | 1 = software owns bus direction through control bit 5 |
| pd_in | input | 8 | Data bus as received |
| pd_out | output | 8 | Data bus as driven |
| pd_oe | output | 1 | 1 = block drives the data bus |
| nwrite | output | 1 | Active-low write line |
| naddrstb | output | 1 | Active-low address strobe |
| ndatastb | output | 1 | Active-low data strobe |
| per_wait | input | 1 | Peripheral wait handshake |
| per_status | input | 5 | Peripheral status lines, shown on status bits 7:3 |

## Verification
The assertions assume that the CPU never raises `cpu_wr` and `cpu_rd` together. They also assume that control bits 0, 1 and 3 stay at 0 while a transfer runs, so the strobe edges they watch come only from the transfer logic. The bench's peripheral model raises `per_wait` only while a strobe is low and lowers it once the strobe is high again. It clears the control register before every transfer, and it waits for each `cpu_done` before issuing the next access. For the timeout cases the model holds `per_wait` low for longer than the limit (version 1.9) or answers only after the limit has passed (version 1.7).

// File: rtl/epp_host.sv
module epp_host #(
  parameter int TMO_CYCLES = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       cpu_busy,
  output logic       cpu_done,
  input  logic       epp_en,
  input  logic       cfg_v17,
  input  logic       cfg_swdir,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  output logic       nwrite,
  output logic       naddrstb,
  output logic       ndatastb,
  input  logic       per_wait,
  input  logic [4:0] per_status
);
  localparam int CW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t           st;
  logic [7:0]    data_q, adr_q, dat_q;
  logic [5:0]    ctr_q;
  logic          tmo_q, is_wr, is_adr, done_q;
  logic [CW-1:0] cnt;

  wire epp_off = cpu_addr >= 3'd3;
  wire start   = epp_en && epp_off && (cpu_wr || cpu_rd) && st == S_IDLE && !tmo_q;
  wire expire  = !cfg_v17 && st != S_IDLE && cnt == CW'(TMO_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      data_q <= '0;
      adr_q  <= '0;
      dat_q  <= '0;
      ctr_q  <= '0;
      tmo_q  <= 1'b0;
      is_wr  <= 1'b0;
      is_adr <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else begin
      done_q <= 1'b0;
      if (cpu_wr) begin
        case (cpu_addr)
          3'd0: data_q <= cpu_wdata;
          3'd1: if (cpu_wdata[0]) tmo_q <= 1'b0;
          3'd2: ctr_q <= cpu_wdata[5:0];
          default: ;
        endcase
      end
      if (start) begin
        st     <= S_SETUP;
        cnt    <= '0;
        is_wr  <= cpu_wr;
        is_adr <= cpu_addr == 3'd3;
        if (cpu_wr) begin
          if (cpu_addr == 3'd3) adr_q <= cpu_wdata;
          else                  dat_q <= cpu_wdata;
        end
      end else if (expire) begin
        st     <= S_IDLE;
        tmo_q  <= 1'b1;
        done_q <= 1'b1;
      end else begin
        if (st != S_IDLE) cnt <= cnt + 1'b1;
        case (st)
          S_SETUP: st <= S_STRB;
          S_STRB: if (per_wait) begin
            st <= S_HOLD;
            if (!is_wr) begin
              if (is_adr) adr_q <= pd_in;
              else        dat_q <= pd_in;
            end
          end
          S_HOLD: if (!per_wait) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  wire strb_on = st == S_STRB;
  wire hw_oe   = (st == S_IDLE) ? !ctr_q[5] : is_wr;

  assign naddrstb = !(ctr_q[3] || (strb_on && is_adr));
  assign ndatastb = !(ctr_q[1] || (strb_on && !is_adr));
  assign nwrite   = !(ctr_q[0] || (st != S_IDLE && is_wr));
  assign pd_oe    = !epp_en ? 1'b1 : (cfg_swdir ? !ctr_q[5] : hw_oe);
  assign pd_out   = (st != S_IDLE && is_wr) ? (is_adr ? adr_q : dat_q) : data_q;
  assign cpu_busy = st != S_IDLE;
  assign cpu_done = done_q;

  always_comb begin
    case (cpu_addr)
      3'd0:    cpu_rdata = pd_oe ? data_q : pd_in;
      3'd1:    cpu_rdata = {per_status, 2'b00, tmo_q};
      3'd2:    cpu_rdata = {2'b00, ctr_q};
      3'd3:    cpu_rdata = adr_q;
      default: cpu_rdata = dat_q;
    endcase
  end
endmodule

module epp_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       epp_en,
  input logic       cfg_v17,
  input logic       cpu_busy,
  input logic       cpu_done,
  input logic       tmo,
  input logic [2:0] cpu_addr,
  input logic [7:0] cpu_rdata,
  input logic [7:0] pd_out,
  input logic       pd_oe,
  input logic       nwrite,
  input logic       naddrstb,
  input logic       ndatastb
);
  a_r4_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_busy && ($fell(naddrstb) || $fell(ndatastb))) |-> ($stable(nwrite) && $stable(pd_out)));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  a_r9_no_tmo_v17: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> !$past(cfg_v17));

  a_r10_tmo_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !cpu_busy) |=> !cpu_busy);

  a_r3_ctr_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == 3'd2) |-> (cpu_rdata[7:6] == 2'b00));

  a_r6_compat_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !epp_en |-> pd_oe);

  a_r12_compat_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!epp_en && !cpu_busy) |=> !cpu_busy);
endmodule

bind epp_host epp_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .epp_en(epp_en), .cfg_v17(cfg_v17),
  .cpu_busy(cpu_busy), .cpu_done(cpu_done), .tmo(tmo_q),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
  .nwrite(nwrite), .naddrstb(naddrstb), .ndatastb(ndatastb)
);

// File: tb/epp_host_bench.sv
module epp_host_bench;
  localparam int TMO = 1250;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_busy, cpu_done;
  logic       epp_en = 1'b0, cfg_v17 = 1'b0, cfg_swdir = 1'b0;
  logic [7:0] pd_in = '0, pd_out;
  logic       pd_oe, nwrite, naddrstb, ndatastb;
  logic       per_wait = 1'b0;
  logic [4:0] per_status = 5'b10110;

  int checks = 0, errors = 0, cycles = 0;
  int resp_dly = 2;
  logic ctr5 = 1'b0;

  typedef struct packed { logic wr; logic adr; logic [7:0] v; } item_t;
  item_t exp_q[$];

  epp_host #(.TMO_CYCLES(TMO)) u_epp_host (.*);

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Peripheral model and scoreboard monitor
  int dly = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      per_wait = 1'b0; dly = 0;
    end else if (cpu_busy && (!naddrstb || !ndatastb) && !per_wait) begin
      if (dly >= resp_dly) begin
        item_t it;
        dly = 0;
        if (exp_q.size() == 0) chk(0, "R2 unexpected transfer", 0, 1);
        else begin
          it = exp_q.pop_front();
          chk(nwrite == !it.wr, "R2/R7 write line", nwrite, !it.wr);
          chk((!naddrstb) == it.adr && (!ndatastb) == !it.adr, "R2/R5 strobe select",
              {naddrstb, ndatastb}, {!it.adr, it.adr});
          chk(pd_oe == (cfg_swdir ? !ctr5 : it.wr), "R6/R11 direction", pd_oe,
              cfg_swdir ? !ctr5 : it.wr);
          if (it.wr) chk(pd_out == it.v, "R2/R5 data out", pd_out, it.v);
          else pd_in = it.v;
        end
        per_wait = 1'b1;
      end else dly++;
    end else if (per_wait && naddrstb && ndatastb) begin
      per_wait = 1'b0;
    end
  end

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!cpu_done && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic epp_write(input logic [2:0] a, input logic [7:0] d);
    int n;
    exp_q.push_back('{wr: 1'b1, adr: a == 3'd3, v: d});
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
    chk(!nwrite && naddrstb && ndatastb && pd_out == d, "R4 setup clock",
        {nwrite, naddrstb, ndatastb, pd_out}, {3'b011, d});
    wait_done(n);
    chk(cpu_done, "R2 done pulse", cpu_done, 1);
  endtask

  task automatic epp_read(input logic [2:0] a, input logic [7:0] v);
    int n;
    exp_q.push_back('{wr: 1'b0, adr: a == 3'd3, v: v});
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
    wait_done(n);
    chk(cpu_done && cpu_rdata == v, "R7 read data", cpu_rdata, v);
  endtask

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    peek(3'd3, r); chk(r == 8'h00, "R1 addr reg reset", r, 0);
    peek(3'd4, r); chk(r == 8'h00, "R1 data reg reset", r, 0);
    peek(3'd2, r); chk(r == 8'h00, "R1 control reset", r, 0);
    peek(3'd1, r); chk(r == {per_status, 3'b000}, "R1 status reset", r, {per_status, 3'b000});
    chk(nwrite && naddrstb && ndatastb, "R1 lines idle", {nwrite, naddrstb, ndatastb}, 3'b111);

    cpu_write(3'd4, 8'h5A);
    chk(!cpu_busy && naddrstb && ndatastb, "R12 compat no transfer", cpu_busy, 0);
    peek(3'd4, r); chk(r == 8'h00, "R12 data reg untouched", r, 0);

    cpu_write(3'd2, 8'hFF); ctr5 = 1'b1;
    peek(3'd2, r); chk(r == 8'h3F, "R3 reserved bits", r, 8'h3F);
    chk(!nwrite && !ndatastb && !naddrstb, "R13 manual lines", {nwrite, ndatastb, naddrstb}, 0);
    chk(pd_oe, "R6 compat drives", pd_oe, 1);
    epp_en = 1'b1;
    @(negedge clk);
    chk(!pd_oe, "R6 idle follows bit5", pd_oe, 0);
    cpu_write(3'd2, 8'h00); ctr5 = 1'b0;
    chk(pd_oe && nwrite && naddrstb && ndatastb, "R13 idle lines", {pd_oe, nwrite, naddrstb, ndatastb}, 4'hF);

    epp_write(3'd3, 8'hA5);
    epp_write(3'd4, 8'h3C);
    epp_write(3'd7, 8'hC3);
    peek(3'd5, r); chk(r == 8'hC3, "R5 shared data reg", r, 8'hC3);
    epp_read(3'd3, 8'h69);
    epp_read(3'd6, 8'h96);

    cfg_swdir = 1'b1;
    epp_read(3'd4, 8'h11);
    cpu_write(3'd2, 8'h20); ctr5 = 1'b1;
    chk(!pd_oe, "R11 software direction", pd_oe, 0);
    cpu_write(3'd2, 8'h00); ctr5 = 1'b0;
    cfg_swdir = 1'b0;

    resp_dly = 100000;
    exp_q.push_back('{wr: 1'b1, adr: 1'b0, v: 8'h77});
    cpu_write(3'd4, 8'h77);
    wait_done(n);
    chk(cpu_done && n >= TMO - 2 && n <= TMO + 2, "R8 abort time", n, TMO);
    chk(nwrite && naddrstb && ndatastb, "R8 lines released", {nwrite, naddrstb, ndatastb}, 3'b111);
    peek(3'd1, r); chk(r[0], "R8 timeout flag", r[0], 1);
    exp_q.delete();
    resp_dly = 2;

    cpu_write(3'd3, 8'h12);
    chk(!cpu_busy, "R10 blocked by flag", cpu_busy, 0);
    cpu_write(3'd1, 8'h01);
    peek(3'd1, r); chk(!r[0], "R10 flag cleared", r[0], 0);
    epp_write(3'd3, 8'h12);

    cfg_v17 = 1'b1;
    resp_dly = TMO + 40;
    epp_write(3'd4, 8'hE7);
    peek(3'd1, r); chk(!r[0], "R9 no timeout in 1.7", r[0], 0);
    resp_dly = 2;

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule